// File: doc/BRIEF.md
# Staged-Reload Clock Divider

This block derives one divided clock from the parent clock that runs it. A small register bus gives access to two words: a control word and a ratio word. Software writes a new division ratio into a staging field of the ratio word. The running divider does not see that value until software writes the control word with two bits set in the same write: the per-output reload-force flag and the global reload trigger.

Only the ratios 4, 5, 6 and 8 are accepted. A staged value outside that set is dropped when the reload fires, and the divider keeps its current ratio. An accepted ratio takes effect at the next boundary of a divided-clock period, so the output never shows a shortened pulse. A clock-enable bit in the control word gates the output. Enabling and disabling also take effect only at a period boundary. As a result, a high phase that is under way when the clock is disabled runs to its end.

The output `div_clk` is a register clocked by the parent clock. A full period of `div_clk` lasts N parent cycles. The output is high for floor(N/2) of those cycles and low for the rest.

Top module: `clkdiv_reload`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the ratio word reads 0x0000_0400 (staged ratio 4), the applied ratio is 4 and `div_clk` stays low.
- R2: The control word is at address 0x0 and the ratio word is at address 0x8. The staged ratio is the 6-bit field at bits 13:8 of the ratio word. A read of the ratio word returns the staged value. A read of any other address returns 0.
- R3: A write to the control word whose data has bit 8 (reload trigger) and bit 1 (reload-force) both at 1 moves a legal staged ratio into the divider. The new ratio starts at the next period boundary.
- R4: Staging a ratio alone has no effect on `div_clk`. A control write with only the trigger bit set, or with only the force bit set, also has no effect on `div_clk`.
- R5: On reload, a staged ratio other than 4, 5, 6 or 8 is ignored and the previous ratio stays in effect. The staged value still reads back unchanged.
- R6: While the divider is enabled with ratio N, every period of `div_clk` lasts N parent cycles, with floor(N/2) cycles high followed by N-floor(N/2) cycles low.
- R7: A change of ratio happens only at a period boundary. Every complete period has the legal shape of some ratio in {4,5,6,8}.
- R8: Bit 25 of the control word is the clock enable, and a read of that bit returns its current value. When the enable is cleared, a high phase already under way completes at full length and the output then stays low. Setting the enable again resumes full periods.
- R9: A control write that clears bits 7:0 and bit 8 while keeping the enable set leaves the applied ratio unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_re |
| div_clk | output | 1 | Divided clock output |

## Verification
The divided output is measured period by period while the divider runs at each of the four legal ratios. Ratio 5 shows that the odd-ratio split puts the shorter phase high, and ratios 4, 6 and 8 confirm that the period length tracks the applied value. The reload handshake is tried with each bit on its own: trigger alone, force alone, and a staged value with no control write. These runs separate a correct two-bit condition from a design that reloads on either bit. Staging 7, 0 and 63 shows that illegal values are dropped. A disable issued just after a rising edge shows that the high phase is not cut short.

// File: rtl/clkdiv_reload.sv
module clkdiv_reload #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int RATIO_W     = 6,
  parameter int RATIO_LSB   = 8,
  parameter int FIELD_IDX   = 1,
  parameter int EN_SHIFT    = 24,
  parameter int TRIG_BIT    = 8,
  parameter int CTRL_OFF    = 0,
  parameter int RATIO_OFF   = 8,
  parameter int RESET_RATIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              div_clk
);
  localparam int EN_BIT = FIELD_IDX + EN_SHIFT;
  localparam int FLAG_W = 8;
  typedef logic [RATIO_W-1:0] ratio_t;

  logic [FLAG_W-1:0] force_q;
  logic              trig_q, en_q, pend_q, run;
  ratio_t            stage_q, pend_ratio, cur_ratio, cnt;
  ratio_t            cnt_n, cur_n;
  logic              wr_ctrl, wr_ratio, reload_hit, wrap, run_n;
  logic              unused_wdata;

  function automatic logic legal(ratio_t r);
    return r == ratio_t'(4) || r == ratio_t'(5) || r == ratio_t'(6) || r == ratio_t'(8);
  endfunction

  assign unused_wdata = ^bus_wdata;
  assign wr_ctrl    = bus_we && bus_addr == ADDR_W'(CTRL_OFF);
  assign wr_ratio   = bus_we && bus_addr == ADDR_W'(RATIO_OFF);
  assign reload_hit = wr_ctrl && bus_wdata[TRIG_BIT] && bus_wdata[FIELD_IDX] && legal(stage_q);

  assign wrap  = cnt == cur_ratio - ratio_t'(1);
  assign cnt_n = wrap ? '0 : cnt + ratio_t'(1);
  assign cur_n = (wrap && pend_q) ? pend_ratio : cur_ratio;
  assign run_n = wrap ? en_q : run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= '0;
      trig_q  <= 1'b0;
      en_q    <= 1'b0;
      stage_q <= ratio_t'(RESET_RATIO);
    end else begin
      if (wr_ctrl) begin
        force_q <= bus_wdata[FLAG_W-1:0];
        trig_q  <= bus_wdata[TRIG_BIT];
        en_q    <= bus_wdata[EN_BIT];
      end
      if (wr_ratio) stage_q <= bus_wdata[RATIO_LSB +: RATIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_ratio <= ratio_t'(RESET_RATIO);
    end else if (reload_hit) begin
      pend_q     <= 1'b1;
      pend_ratio <= stage_q;
    end else if (wrap) begin
      pend_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cur_ratio <= ratio_t'(RESET_RATIO);
      run       <= 1'b0;
      div_clk   <= 1'b0;
    end else begin
      cnt       <= cnt_n;
      cur_ratio <= cur_n;
      run       <= run_n;
      div_clk   <= run_n && (cnt_n < (cur_n >> 1));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == ADDR_W'(CTRL_OFF)) begin
        bus_rdata[FLAG_W-1:0] = force_q;
        bus_rdata[TRIG_BIT]   = trig_q;
        bus_rdata[EN_BIT]     = en_q;
      end else if (bus_addr == ADDR_W'(RATIO_OFF)) begin
        bus_rdata[RATIO_LSB +: RATIO_W] = stage_q;
      end
    end
  end
endmodule

// File: rtl/clkdiv_reload_chk.sv
module clkdiv_reload_chk #(
  parameter int RATIO_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] cur_ratio,
  input logic [RATIO_W-1:0] cnt,
  input logic               div_clk
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!div_clk && cur_ratio == RATIO_W'(4)));

  a_r5_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ratio == RATIO_W'(4) || cur_ratio == RATIO_W'(5) ||
    cur_ratio == RATIO_W'(6) || cur_ratio == RATIO_W'(8));

  a_r7_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_ratio) |-> ($past(cnt) == $past(cur_ratio) - RATIO_W'(1) && cnt == '0));

  a_r6_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> cnt == '0);

  a_r8_full_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_clk) |-> cnt == (cur_ratio >> 1));
endmodule

bind clkdiv_reload clkdiv_reload_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_ratio(cur_ratio), .cnt(cnt), .div_clk(div_clk)
);

// File: tb/test_clkdiv_reload.sv
`timescale 1ns/1ps
module test_clkdiv_reload;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        div_clk;

  int checks = 0;
  int errors = 0;
  int exp_n[$];
  string exp_req[$];
  bit chk_on = 0;
  int discard = 0;
  bit done = 0;

  localparam logic [31:0] EN  = 32'h0200_0000;
  localparam logic [31:0] FRC = 32'h0000_0002;
  localparam logic [31:0] TRG = 32'h0000_0100;

  always #2.5 clk = ~clk;

  clkdiv_reload i_clkdiv_reload (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .div_clk(div_clk)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    check(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
    bus_re = 1'b0;
  endtask

  task automatic push(int n, int cnt, string req);
    repeat (30) @(negedge clk);
    for (int i = 0; i < cnt; i++) begin
      exp_n.push_back(n);
      exp_req.push_back(req);
    end
    while (exp_n.size() > 0) @(negedge clk);
  endtask

  task automatic reload();
    wr(4'h0, EN | FRC | TRG);
    wr(4'h0, EN);
  endtask

  // Monitor: measure each complete period of div_clk
  initial begin
    bit prev = 0;
    bit started = 0;
    int hi = 0;
    int lo = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        started = 0; prev = 0;
      end else if (div_clk && !prev) begin
        if (started && chk_on) begin
          if (discard > 0) discard--;
          else if (exp_n.size() > 0) begin
            int n;
            string r;
            n = exp_n.pop_front();
            r = exp_req.pop_front();
            check(hi == n / 2, {r, " high"}, hi, n / 2);
            check(lo == n - n / 2, {r, " low"}, lo, n - n / 2);
          end else begin
            int t;
            t = hi + lo;
            check((t == 4 || t == 5 || t == 6 || t == 8) && hi == t / 2,
                  "R7 period shape", hi * 100 + lo, (t / 2) * 100 + (t - t / 2));
          end
        end
        started = 1; hi = 1; lo = 0;
      end else if (div_clk) hi++;
      else lo++;
      prev = div_clk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hc;
    bit seen_low;
    bit late_high;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(4'h0, 32'h0, "R1 ctrl reset");
    rd_chk(4'h8, 32'h400, "R1 ratio reset");
    hc = 0;
    repeat (20) begin @(negedge clk); if (div_clk) hc++; end
    check(hc == 0, "R1 output low after reset", hc, 0);
    rd_chk(4'h4, 32'h0, "R2 unmapped read");

    // R8 enable, R6 ratio 4
    wr(4'h0, EN);
    rd_chk(4'h0, EN, "R8 enable readback");
    discard = 1; chk_on = 1;
    push(4, 3, "R6 ratio 4");

    // R4 staging alone and single handshake bits
    wr(4'h8, 32'd5 << 8);
    rd_chk(4'h8, 32'h500, "R2 staged readback");
    push(4, 3, "R4 stage only");
    wr(4'h0, EN | TRG);
    push(4, 3, "R4 trigger only");
    wr(4'h0, EN | FRC);
    push(4, 3, "R4 force only");

    // R3 reload to 5, R9 clearing write
    wr(4'h0, EN | FRC | TRG);
    push(5, 3, "R3 reload to 5");
    wr(4'h0, EN);
    rd_chk(4'h0, EN, "R9 cleared ctrl");
    push(5, 3, "R9 ratio kept after clear");

    wr(4'h8, 32'd6 << 8); reload();
    push(6, 3, "R6 ratio 6");
    wr(4'h8, 32'd8 << 8); reload();
    push(8, 3, "R6 ratio 8");

    // R5 illegal ratios
    wr(4'h8, 32'd7 << 8); reload();
    rd_chk(4'h8, 32'h700, "R5 illegal staged readback");
    push(8, 2, "R5 ratio 7 ignored");
    wr(4'h8, 32'd0); reload();
    push(8, 2, "R5 ratio 0 ignored");
    wr(4'h8, 32'd63 << 8); reload();
    push(8, 2, "R5 ratio 63 ignored");

    // R8 disable during high phase
    chk_on = 0;
    @(negedge clk);
    while (div_clk) @(negedge clk);
    while (!div_clk) @(negedge clk);
    hc = 1; seen_low = 0; late_high = 0;
    fork
      wr(4'h0, 32'h0);
      repeat (14) begin
        @(negedge clk);
        if (div_clk && !seen_low) hc++;
        else if (!div_clk) seen_low = 1;
        else late_high = 1;
      end
    join
    check(hc == 4, "R8 high phase completes", hc, 4);
    check(!late_high, "R8 no pulse after disable", int'(late_high), 0);
    rd_chk(4'h0, 32'h0, "R8 disable readback");
    hc = 0;
    repeat (40) begin @(negedge clk); if (div_clk) hc++; end
    check(hc == 0, "R8 low while disabled", hc, 0);

    // R8 resume, R7 switch 8 -> 4 while running
    wr(4'h0, EN);
    discard = 1; chk_on = 1;
    push(8, 2, "R8 resume");
    wr(4'h8, 32'd4 << 8); reload();
    repeat (60) @(negedge clk);
    push(4, 2, "R7 after switch");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule